// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load-Stall Controller

This block is the steering logic for an in-order, five-stage integer pipeline with fetch, decode, execute, memory and write-back stages. It is purely combinational. It takes the register numbers that the pipeline registers already hold and returns mux selects and hold controls. An instruction in execute that needs a value not yet written back takes it from one of two places. The first is the result held between execute and memory. The second is the result held between memory and write-back. When both hold a matching result, the younger one wins. Register zero is never treated as a producer.

The result of a load is not available until the load leaves the memory stage. A decode-stage instruction that reads a loaded register in the very next slot therefore has to wait one cycle. The block detects this in decode. In that cycle it freezes the program counter and the fetch/decode register and sends a bubble into execute. A store that only writes the loaded register to memory does not wait. Its data is picked up from the write-back result while the store is in the memory stage. Write-after-read and write-after-write conflicts cannot occur in this pipeline, because reads happen in decode and writes happen in write-back, in program order. The block therefore does not check for them.

Top module: `hz_fwd_unit`

## Requirements
- R1: `fwd_a` steers the execute operand read from `ex_src1`, and `fwd_b` steers the one read from `ex_src2`. The code 2'b00 selects the register file, 2'b10 selects the execute/memory result and 2'b01 selects the memory/write-back result. Code 2'b11 never appears.
- R2: When the operand register equals `mem_dst`, `mem_we` is 1 and `mem_is_load` is 0, the select is 2'b10, with no stall.
- R3: When the operand register equals `wb_dst` with `wb_we` at 1, and R2 does not apply, the select is 2'b01.
- R4: When both later stages write the operand register, the execute/memory result (2'b10) takes priority.
- R5: A destination of register 0, or a stage with its write enable at 0, never causes a non-zero select, `fwd_st` or a stall.
- R6: The stall fires when `ex_is_load`, `ex_we` and a non-zero `ex_dst` are all present and `ex_dst` matches a source that decode reads. That source is `id_src1` with `id_use1`, or `id_src2` with `id_use2` when `id_is_store` is 0. During a stall `pc_hold`, `ifid_hold` and `idex_bubble` are all 1; otherwise all three are 0.
- R7: A decode-stage store whose data register (`id_src2`) matches a load in execute, while its base register does not, causes no stall.
- R8: A load in the memory stage is never an execute/memory forwarding source. An operand matching it gets 2'b01 if write-back also matches, else 2'b00.
- R9: `fwd_st` is 1 exactly when `mem_is_store` is 1, `wb_we` is 1, `wb_dst` is non-zero and `mem_st_src` equals `wb_dst`.
- R10: The stall depends only on the execute stage. A load in memory or write-back that matches a decode source causes no stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_src1 | input | REG_AW | first source register of the decode instruction |
| id_src2 | input | REG_AW | second source register of the decode instruction |
| id_use1 | input | 1 | decode instruction reads id_src1 |
| id_use2 | input | 1 | decode instruction reads id_src2 |
| id_is_store | input | 1 | decode instruction is a store (id_src2 is its data) |
| ex_src1 | input | REG_AW | first source register in execute |
| ex_src2 | input | REG_AW | second source register in execute |
| ex_dst | input | REG_AW | destination register in execute |
| ex_we | input | 1 | execute instruction writes a register |
| ex_is_load | input | 1 | execute instruction is a load |
| mem_dst | input | REG_AW | destination register in memory stage |
| mem_we | input | 1 | memory-stage instruction writes a register |
| mem_is_load | input | 1 | memory-stage instruction is a load |
| mem_is_store | input | 1 | memory-stage instruction is a store |
| mem_st_src | input | REG_AW | data register of the memory-stage store |
| wb_dst | input | REG_AW | destination register in write-back |
| wb_we | input | 1 | write-back instruction writes a register |
| fwd_a | output | 2 | select for execute operand A |
| fwd_b | output | 2 | select for execute operand B |
| fwd_st | output | 1 | store data taken from the write-back result |
| pc_hold | output | 1 | freeze program counter |
| ifid_hold | output | 1 | freeze fetch/decode register |
| idex_bubble | output | 1 | insert a bubble into execute |

## Verification
The bench builds the block with the default 5-bit register number. It draws every register field from the four values 0 to 3, so matches, double matches and register-zero cases occur in most cycles rather than rarely. Directed vectors cover each priority and exemption on its own. These include the load in memory against a younger write-back match, and the store whose base register, rather than its data register, depends on a load.

// File: rtl/hz_pkg.sv
package hz_pkg;
  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } fwd_src_e;
endpackage

// File: rtl/hz_operand_ctl.sv
module hz_operand_ctl
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] opnd_reg,
  input  logic [REG_AW-1:0] young_dst,
  input  logic              young_we,
  input  logic              young_load,
  input  logic [REG_AW-1:0] old_dst,
  input  logic              old_we,
  output fwd_src_e          sel,
  output logic              young_hit,
  output logic              old_hit
);
  // A stage supplies a value when it writes a real register that matches.
  function automatic logic produces(input logic [REG_AW-1:0] want,
                                    input logic [REG_AW-1:0] dst,
                                    input logic we);
    return we && (dst != '0) && (dst == want);
  endfunction

  always_comb begin
    // A load still in the memory stage holds an address, not data.
    young_hit = produces(opnd_reg, young_dst, young_we) && !young_load;
    old_hit   = produces(opnd_reg, old_dst, old_we);
    if (young_hit)    sel = SRC_EXMEM;
    else if (old_hit) sel = SRC_MEMWB;
    else              sel = SRC_REGFILE;
  end
endmodule

// File: rtl/hz_store_data_ctl.sv
module hz_store_data_ctl #(
  parameter int REG_AW = 5
) (
  input  logic              st_valid,
  input  logic [REG_AW-1:0] st_data_reg,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_we,
  output logic              st_take_wb
);
  always_comb begin
    st_take_wb = st_valid && wb_we && (wb_dst != '0) && (wb_dst == st_data_reg);
  end
endmodule

// File: rtl/hz_load_use_det.sv
module hz_load_use_det #(
  parameter int REG_AW = 5,
  parameter int NSRC   = 2
) (
  input  logic [NSRC-1:0][REG_AW-1:0] dec_src,
  input  logic [NSRC-1:0]             dec_reads,
  input  logic [REG_AW-1:0]           ld_dst,
  input  logic                        ld_we,
  input  logic                        ld_valid,
  output logic [NSRC-1:0]             src_waits,
  output logic                        stall
);
  logic ld_live;
  assign ld_live = ld_valid && ld_we && (ld_dst != '0);

  for (genvar g = 0; g < NSRC; g++) begin : g_src
    assign src_waits[g] = ld_live && dec_reads[g] && (dec_src[g] == ld_dst);
  end

  assign stall = |src_waits;
endmodule

// File: rtl/hz_fwd_unit.sv
module hz_fwd_unit
  import hz_pkg::*;
#(
  parameter int REG_AW = 5
) (
  input  logic [REG_AW-1:0] id_src1,
  input  logic [REG_AW-1:0] id_src2,
  input  logic              id_use1,
  input  logic              id_use2,
  input  logic              id_is_store,
  input  logic [REG_AW-1:0] ex_src1,
  input  logic [REG_AW-1:0] ex_src2,
  input  logic [REG_AW-1:0] ex_dst,
  input  logic              ex_we,
  input  logic              ex_is_load,
  input  logic [REG_AW-1:0] mem_dst,
  input  logic              mem_we,
  input  logic              mem_is_load,
  input  logic              mem_is_store,
  input  logic [REG_AW-1:0] mem_st_src,
  input  logic [REG_AW-1:0] wb_dst,
  input  logic              wb_we,
  output logic [1:0]        fwd_a,
  output logic [1:0]        fwd_b,
  output logic              fwd_st,
  output logic              pc_hold,
  output logic              ifid_hold,
  output logic              idex_bubble
);
  localparam int NOPND = 2;
  localparam int NDSRC = 2;

  logic [NOPND-1:0][REG_AW-1:0] opnd_regs;
  fwd_src_e [NOPND-1:0]         opnd_sel;
  logic [NOPND-1:0]             opnd_young_hit;
  logic [NOPND-1:0]             opnd_old_hit;

  logic [NDSRC-1:0][REG_AW-1:0] dec_src;
  logic [NDSRC-1:0]             dec_reads;
  logic [NDSRC-1:0]             dec_waits;
  logic                         load_use_stall;

  assign opnd_regs[0] = ex_src1;
  assign opnd_regs[1] = ex_src2;

  for (genvar g = 0; g < NOPND; g++) begin : g_opnd
    hz_operand_ctl #(.REG_AW(REG_AW)) u_opnd (
      .opnd_reg  (opnd_regs[g]),
      .young_dst (mem_dst),
      .young_we  (mem_we),
      .young_load(mem_is_load),
      .old_dst   (wb_dst),
      .old_we    (wb_we),
      .sel       (opnd_sel[g]),
      .young_hit (opnd_young_hit[g]),
      .old_hit   (opnd_old_hit[g])
    );
  end

  assign fwd_a = opnd_sel[0];
  assign fwd_b = opnd_sel[1];

  hz_store_data_ctl #(.REG_AW(REG_AW)) u_st (
    .st_valid   (mem_is_store),
    .st_data_reg(mem_st_src),
    .wb_dst     (wb_dst),
    .wb_we      (wb_we),
    .st_take_wb (fwd_st)
  );

  // Store data is served later by the memory-stage bypass, so it is not a stalling read.
  assign dec_src[0]   = id_src1;
  assign dec_src[1]   = id_src2;
  assign dec_reads[0] = id_use1;
  assign dec_reads[1] = id_use2 && !id_is_store;

  hz_load_use_det #(.REG_AW(REG_AW), .NSRC(NDSRC)) u_lu (
    .dec_src  (dec_src),
    .dec_reads(dec_reads),
    .ld_dst   (ex_dst),
    .ld_we    (ex_we),
    .ld_valid (ex_is_load),
    .src_waits(dec_waits),
    .stall    (load_use_stall)
  );

  assign pc_hold     = load_use_stall;
  assign ifid_hold   = load_use_stall;
  assign idex_bubble = load_use_stall;
endmodule

// File: rtl/hz_fwd_unit_chk.sv
module hz_fwd_unit_chk #(
  parameter int REG_AW = 5
) (
  input logic [REG_AW-1:0] id_src1,
  input logic [REG_AW-1:0] id_src2,
  input logic              id_use1,
  input logic              id_use2,
  input logic              id_is_store,
  input logic [REG_AW-1:0] ex_src1,
  input logic [REG_AW-1:0] ex_src2,
  input logic [REG_AW-1:0] ex_dst,
  input logic              ex_we,
  input logic              ex_is_load,
  input logic [REG_AW-1:0] mem_dst,
  input logic              mem_we,
  input logic              mem_is_load,
  input logic              mem_is_store,
  input logic [REG_AW-1:0] mem_st_src,
  input logic [REG_AW-1:0] wb_dst,
  input logic              wb_we,
  input logic [1:0]        fwd_a,
  input logic [1:0]        fwd_b,
  input logic              fwd_st,
  input logic              pc_hold,
  input logic              ifid_hold,
  input logic              idex_bubble,
  input logic [1:0]        dec_waits
);
  always_comb begin
    a_r1_no_code_3: assert (fwd_a != 2'b11 && fwd_b != 2'b11);
    a_r2_exmem_needs_writer: assert (fwd_a != 2'b10 || (mem_we && mem_dst == ex_src1));
    a_r3_memwb_needs_writer: assert (fwd_b != 2'b01 || (wb_we && wb_dst == ex_src2));
    a_r5_zero_never_fwd: assert ((fwd_a == 2'b00 || ex_src1 != '0) && (fwd_b == 2'b00 || ex_src2 != '0));
    a_r8_load_not_exmem_src: assert (!mem_is_load || (fwd_a != 2'b10 && fwd_b != 2'b10));
    a_r6_holds_agree: assert (pc_hold == ifid_hold && ifid_hold == idex_bubble);
    a_r6_stall_has_cause: assert (!pc_hold || (dec_waits != 2'b00 && ex_is_load));
    a_r9_store_fwd_needs_store: assert (!fwd_st || (mem_is_store && wb_we && mem_st_src != '0));
  end
endmodule

bind hz_fwd_unit hz_fwd_unit_chk #(.REG_AW(REG_AW)) u_chk (
  .id_src1(id_src1), .id_src2(id_src2), .id_use1(id_use1), .id_use2(id_use2),
  .id_is_store(id_is_store), .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_dst(ex_dst),
  .ex_we(ex_we), .ex_is_load(ex_is_load), .mem_dst(mem_dst), .mem_we(mem_we),
  .mem_is_load(mem_is_load), .mem_is_store(mem_is_store), .mem_st_src(mem_st_src),
  .wb_dst(wb_dst), .wb_we(wb_we), .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_st(fwd_st),
  .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble),
  .dec_waits(dec_waits)
);

// File: tb/hz_fwd_unit_bench.sv
module hz_fwd_unit_bench;
  localparam int AW = 5;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [AW-1:0] id_src1, id_src2, ex_src1, ex_src2, ex_dst, mem_dst, mem_st_src, wb_dst;
  logic id_use1, id_use2, id_is_store, ex_we, ex_is_load, mem_we, mem_is_load, mem_is_store, wb_we;
  logic [1:0] fwd_a, fwd_b;
  logic fwd_st, pc_hold, ifid_hold, idex_bubble;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  hz_fwd_unit #(.REG_AW(AW)) u_hz_fwd_unit (
    .id_src1(id_src1), .id_src2(id_src2), .id_use1(id_use1), .id_use2(id_use2),
    .id_is_store(id_is_store), .ex_src1(ex_src1), .ex_src2(ex_src2), .ex_dst(ex_dst),
    .ex_we(ex_we), .ex_is_load(ex_is_load), .mem_dst(mem_dst), .mem_we(mem_we),
    .mem_is_load(mem_is_load), .mem_is_store(mem_is_store), .mem_st_src(mem_st_src),
    .wb_dst(wb_dst), .wb_we(wb_we), .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_st(fwd_st),
    .pc_hold(pc_hold), .ifid_hold(ifid_hold), .idex_bubble(idex_bubble)
  );

  // Reference: walk the producers from youngest to oldest.
  function automatic logic [1:0] ref_sel(input int r);
    int order_dst[2];
    bit order_ok[2];
    logic [1:0] code[2];
    order_dst[0] = mem_dst; order_ok[0] = mem_we && !mem_is_load; code[0] = 2'b10;
    order_dst[1] = wb_dst;  order_ok[1] = wb_we;                  code[1] = 2'b01;
    if (r == 0) return 2'b00;
    for (int k = 0; k < 2; k++)
      if (order_ok[k] && order_dst[k] == r) return code[k];
    return 2'b00;
  endfunction

  function automatic bit ref_stall();
    int need[$];
    if (!(ex_is_load && ex_we) || ex_dst == 0) return 1'b0;
    if (id_use1) need.push_back(int'(id_src1));
    if (id_use2 && !id_is_store) need.push_back(int'(id_src2));
    foreach (need[i]) if (need[i] == int'(ex_dst)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic bit ref_st();
    return mem_is_store && wb_we && wb_dst != 0 && int'(wb_dst) == int'(mem_st_src);
  endfunction

  task automatic check(input string tag);
    logic [1:0] ea, eb;
    bit es, est;
    ea = ref_sel(int'(ex_src1)); eb = ref_sel(int'(ex_src2));
    es = ref_stall(); est = ref_st();
    n_checks++;
    if (fwd_a !== ea || fwd_b !== eb || fwd_st !== est ||
        pc_hold !== es || ifid_hold !== es || idex_bubble !== es) begin
      n_fail++;
      $display("FAIL %s: a=%b b=%b st=%b hold=%b%b%b expected a=%b b=%b st=%b hold=%b",
               tag, fwd_a, fwd_b, fwd_st, pc_hold, ifid_hold, idex_bubble, ea, eb, est, es);
    end
  endtask

  task automatic idle();
    id_src1 = 0; id_src2 = 0; id_use1 = 0; id_use2 = 0; id_is_store = 0;
    ex_src1 = 0; ex_src2 = 0; ex_dst = 0; ex_we = 0; ex_is_load = 0;
    mem_dst = 0; mem_we = 0; mem_is_load = 0; mem_is_store = 0; mem_st_src = 0;
    wb_dst = 0; wb_we = 0;
  endtask

  task automatic settle_and_check(input string tag);
    @(negedge clk);
    check(tag);
    @(posedge clk);
  endtask

  initial begin
    idle();
    @(posedge clk);
    settle_and_check("R1 idle state");

    idle(); ex_src1 = 3; mem_dst = 3; mem_we = 1; settle_and_check("R2 A from exec/mem");
    if (fwd_a != 2'b00) ; // value sampled inside check
    idle(); ex_src2 = 7; wb_dst = 7; wb_we = 1; settle_and_check("R3 B from mem/wb");
    idle(); ex_src1 = 4; ex_src2 = 4; mem_dst = 4; mem_we = 1; wb_dst = 4; wb_we = 1;
    settle_and_check("R4 younger wins");
    idle(); ex_src1 = 0; mem_dst = 0; mem_we = 1; wb_dst = 0; wb_we = 1; settle_and_check("R5 reg zero");
    idle(); ex_src1 = 5; mem_dst = 5; mem_we = 0; wb_dst = 5; wb_we = 0; settle_and_check("R5 we clear");
    idle(); id_src1 = 0; id_use1 = 1; ex_dst = 0; ex_we = 1; ex_is_load = 1; settle_and_check("R5 load to r0");
    idle(); id_src1 = 6; id_use1 = 1; ex_dst = 6; ex_we = 1; ex_is_load = 1; settle_and_check("R6 stall src1");
    idle(); id_src2 = 6; id_use2 = 1; ex_dst = 6; ex_we = 1; ex_is_load = 1; settle_and_check("R6 stall src2");
    idle(); id_src2 = 6; id_use2 = 0; ex_dst = 6; ex_we = 1; ex_is_load = 1; settle_and_check("R6 unused src");
    idle(); id_src1 = 2; id_use1 = 1; id_src2 = 9; id_use2 = 1; id_is_store = 1;
    ex_dst = 9; ex_we = 1; ex_is_load = 1; settle_and_check("R7 store data no stall");
    idle(); id_src1 = 9; id_use1 = 1; id_src2 = 2; id_use2 = 1; id_is_store = 1;
    ex_dst = 9; ex_we = 1; ex_is_load = 1; settle_and_check("R7 store base stalls");
    idle(); ex_src2 = 8; mem_dst = 8; mem_we = 1; mem_is_load = 1; settle_and_check("R8 load in mem, regfile");
    idle(); ex_src1 = 8; mem_dst = 8; mem_we = 1; mem_is_load = 1; wb_dst = 8; wb_we = 1;
    settle_and_check("R8 load in mem, wb used");
    idle(); mem_is_store = 1; mem_st_src = 11; wb_dst = 11; wb_we = 1; settle_and_check("R9 store data bypass");
    idle(); mem_is_store = 0; mem_st_src = 11; wb_dst = 11; wb_we = 1; settle_and_check("R9 not a store");
    idle(); id_src1 = 12; id_use1 = 1; mem_dst = 12; mem_we = 1; mem_is_load = 1;
    wb_dst = 12; wb_we = 1; settle_and_check("R10 older load no stall");

    for (int i = 0; i < 3000; i++) begin
      id_src1 = AW'($urandom_range(3)); id_src2 = AW'($urandom_range(3));
      ex_src1 = AW'($urandom_range(3)); ex_src2 = AW'($urandom_range(3));
      ex_dst = AW'($urandom_range(3)); mem_dst = AW'($urandom_range(3));
      mem_st_src = AW'($urandom_range(3)); wb_dst = AW'($urandom_range(3));
      {id_use1, id_use2, id_is_store, ex_we, ex_is_load} = 5'($urandom);
      {mem_we, mem_is_load, mem_is_store, wb_we} = 4'($urandom);
      settle_and_check("R1 R4 R6 R9 random mix");
    end
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 100000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run incomplete after %0d cycles, expected completion", cyc);
    end
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule